// File: doc/BRIEF.md
# Single-Wire Pulse-Width Output Expander

This block recovers bits from one serial line that carries clock and data together, and drives a bank of parallel outputs from them. The line rests high. Each bit is a dip to low and a return to high. A short dip means one and a long dip means zero. The bit is decided and shifted in when the line returns high. A fast system clock samples the line through a synchronizer and times each low interval in clock cycles.

Shifting only changes an internal register, so the outputs never show a partly received frame. When the line has stayed high for a programmable idle time after at least one accepted bit, the shift register is copied to the outputs in a single clock edge, and a one-cycle strobe marks the update. Dips shorter than a programmable glitch count are discarded. Three inputs set the glitch count, the zero/one decision threshold and the idle timeout, all in system clocks.

Top module: `pwse_expander`

## Requirements
- R1: While `rst_n` is low, `par_o` is all zeros and `strobe_o` is 0. The asynchronous reset also clears the shift register and all counters.
- R2: A low interval of L sampled cycles with `glitch_i` <= L <= `thresh_i` shifts in a 1.
- R3: A low interval with L > `thresh_i` and L >= `glitch_i` shifts in a 0.
- R4: The low-time counter saturates at 2^CW-1 and does not wrap. Any low interval longer than that still decodes as 0 when `thresh_i` < 2^CW-1.
- R5: A low interval with L < `glitch_i` shifts nothing and does not count as a received bit.
- R6: Bits enter at bit 0 and move toward the top. After eight shifts, the first bit received sits at `par_o[7]` and the last at `par_o[0]`.
- R7: `par_o` changes only in the cycle where `strobe_o` is 1. It holds its value while bits are arriving.
- R8: After the rising edge that ends the last bit, with the line held high, `par_o` takes the shift register value at the (`idle_i`+3)-th rising clock edge. The first edge counted is the one that first samples `line_i` high. `strobe_o` is 1 for exactly that one cycle. `idle_i` must be at least 3.
- R9: With no accepted bit since the last update, a long high period produces no strobe and leaves `par_o` unchanged.
- R10: The shift register is not cleared at an update. A frame of fewer than eight bits shifts the previous contents up by its bit count. A frame of more than eight bits keeps the last eight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the line |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| line_i | input | 1 | Combined clock/data line, idle high |
| glitch_i | input | CW | Shortest low interval, in clocks, accepted as a bit |
| thresh_i | input | CW | Longest low interval, in clocks, that decodes as 1 |
| idle_i | input | CW | High time, in clocks, that closes a frame |
| par_o | output | NOUT | Latched parallel outputs |
| strobe_o | output | 1 | One-cycle pulse when `par_o` is updated |

## Verification
The input passes through two synchronizer flops. A low interval driven for L clock periods is therefore counted as exactly L, and its bit is shifted two edges after the line returns high. The outputs update at edge `idle_i`+3 after the rise is driven, and the strobe falls one edge later. The bench drives the line on falling clock edges and counts falling edges from each rise. In each frame it samples one cycle before the expected update to see old data with no strobe, at the update to see new data with the strobe, and one cycle later to see the strobe gone. It also samples two cycles after every bit to confirm the outputs have not moved.

// File: rtl/pwse_pkg.sv
package pwse_pkg;
  // Outcome of one completed low interval
  typedef enum logic [1:0] {
    DEC_IGNORE = 2'd0,
    DEC_ZERO   = 2'd1,
    DEC_ONE    = 2'd2
  } dec_e;

  localparam int DEF_NOUT        = 8;
  localparam int DEF_CW          = 8;
  localparam int DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/pwse_sync.sv
module pwse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s_o,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES:0] chain;
  logic            prev_q;

  assign chain[0] = line_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g+1] <= 1'b1;
      else        chain[g+1] <= chain[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain[STAGES];
  end

  assign line_s_o = chain[STAGES];
  assign fall_o   = prev_q & ~chain[STAGES];
  assign rise_o   = ~prev_q & chain[STAGES];
endmodule

// File: rtl/pwse_lowtimer.sv
module pwse_lowtimer
  import pwse_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_s,
  input  logic          fall,
  input  logic          rise,
  input  logic [CW-1:0] glitch_i,
  input  logic [CW-1:0] thresh_i,
  output logic          dec_valid_o,
  output logic          dec_bit_o,
  output logic [CW-1:0] low_len_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  dec_e          dec;

  // Count only while the line is low; restart at each falling edge
  always_comb begin
    cnt_en = ~line_s;
    if (fall)                 cnt_d = CNT_ONE;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                      cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Decide the bit in the cycle the line is first seen high again
  always_comb begin
    dec = DEC_IGNORE;
    if (rise) begin
      if (cnt_q < glitch_i)      dec = DEC_IGNORE;
      else if (cnt_q > thresh_i) dec = DEC_ZERO;
      else                       dec = DEC_ONE;
    end
  end

  assign dec_valid_o = (dec != DEC_IGNORE);
  assign dec_bit_o   = (dec == DEC_ONE);
  assign low_len_o   = cnt_q;
endmodule

// File: rtl/pwse_framer.sv
module pwse_framer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_s,
  input  logic          rise,
  input  logic          shift_v,
  input  logic [CW-1:0] idle_i,
  output logic          latch_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [CW-1:0] hcnt_q, hcnt_d;
  logic          pend_q, pend_d;
  logic          latch;

  always_comb begin
    if (!line_s)               hcnt_d = '0;
    else if (rise)             hcnt_d = CNT_ONE;
    else if (hcnt_q == CNT_MAX) hcnt_d = hcnt_q;
    else                       hcnt_d = hcnt_q + CNT_ONE;
  end

  // Close the frame once the high time reaches the idle limit with a bit pending
  always_comb begin
    latch  = line_s & pend_q & (hcnt_q != '0) & (hcnt_q >= idle_i);
    pend_d = pend_q;
    if (latch)   pend_d = 1'b0;
    if (shift_v) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      pend_q <= 1'b0;
    end else begin
      hcnt_q <= hcnt_d;
      pend_q <= pend_d;
    end
  end

  assign latch_o = latch;
endmodule

// File: rtl/pwse_shiftlatch.sv
module pwse_shiftlatch #(
  parameter int NOUT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_v,
  input  logic            bit_i,
  input  logic            latch_i,
  output logic [NOUT-1:0] par_o,
  output logic            strobe_o
);
  logic [NOUT-1:0] sreg_q, sreg_d;
  logic [NOUT-1:0] out_q;
  logic            strobe_q;

  always_comb begin
    sreg_d = {sreg_q[NOUT-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sreg_q <= '0;
    else if (shift_v) sreg_q <= sreg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_q <= '0;
    else if (latch_i) out_q <= sreg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= latch_i;
  end

  assign par_o    = out_q;
  assign strobe_o = strobe_q;
endmodule

// File: rtl/pwse_expander.sv
module pwse_expander
  import pwse_pkg::*;
#(
  parameter int NOUT        = DEF_NOUT,
  parameter int CW          = DEF_CW,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_i,
  input  logic [CW-1:0]   glitch_i,
  input  logic [CW-1:0]   thresh_i,
  input  logic [CW-1:0]   idle_i,
  output logic [NOUT-1:0] par_o,
  output logic            strobe_o
);
  logic [1:0]    rst_pipe;
  logic          rst_int_n;
  logic          line_s, fall, rise;
  logic          shift_v, dec_bit, latch;
  logic [CW-1:0] low_len;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  pwse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .line_i   (line_i),
    .line_s_o (line_s),
    .fall_o   (fall),
    .rise_o   (rise)
  );

  pwse_lowtimer #(.CW(CW)) u_low (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .line_s      (line_s),
    .fall        (fall),
    .rise        (rise),
    .glitch_i    (glitch_i),
    .thresh_i    (thresh_i),
    .dec_valid_o (shift_v),
    .dec_bit_o   (dec_bit),
    .low_len_o   (low_len)
  );

  pwse_framer #(.CW(CW)) u_frame (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .line_s  (line_s),
    .rise    (rise),
    .shift_v (shift_v),
    .idle_i  (idle_i),
    .latch_o (latch)
  );

  pwse_shiftlatch #(.NOUT(NOUT)) u_shl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .shift_v  (shift_v),
    .bit_i    (dec_bit),
    .latch_i  (latch),
    .par_o    (par_o),
    .strobe_o (strobe_o)
  );
endmodule

// File: rtl/pwse_expander_chk.sv
module pwse_expander_chk #(
  parameter int NOUT = 8,
  parameter int CW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            line_s,
  input logic            fall,
  input logic            rise,
  input logic            shift_v,
  input logic            dec_bit,
  input logic [CW-1:0]   low_len,
  input logic [CW-1:0]   glitch_i,
  input logic [CW-1:0]   thresh_i,
  input logic [NOUT-1:0] par_o,
  input logic            strobe_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (par_o == '0 && !strobe_o));

  p_mid_low_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && low_len >= glitch_i && low_len <= thresh_i) |-> (shift_v && dec_bit));

  p_long_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && low_len >= glitch_i && low_len > thresh_i) |-> (shift_v && !dec_bit));

  p_count_saturates_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_s && !fall && low_len == CNT_MAX) |=> (low_len == CNT_MAX));

  p_short_low_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && low_len < glitch_i) |-> !shift_v);

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_o |-> $stable(par_o));

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);

  p_strobe_after_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_o) |-> $past(line_s));
endmodule

bind pwse_expander pwse_expander_chk #(.NOUT(NOUT), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .line_s   (line_s),
  .fall     (fall),
  .rise     (rise),
  .shift_v  (shift_v),
  .dec_bit  (dec_bit),
  .low_len  (low_len),
  .glitch_i (glitch_i),
  .thresh_i (thresh_i),
  .par_o    (par_o),
  .strobe_o (strobe_o)
);

// File: tb/pwse_expander_tb.sv
module pwse_expander_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NOUT       = 8;
  localparam int CW         = 8;
  localparam int GAP        = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            line_i;
  logic [CW-1:0]   glitch_i, thresh_i, idle_i;
  logic [NOUT-1:0] par_o;
  logic            strobe_o;

  int        total = 0;
  int        bad   = 0;
  bit        done  = 0;
  logic [7:0] sreg_m, out_m;
  bit        pend_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwse_expander #(.NOUT(NOUT), .CW(CW)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (line_i),
    .glitch_i (glitch_i),
    .thresh_i (thresh_i),
    .idle_i   (idle_i),
    .par_o    (par_o),
    .strobe_o (strobe_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One bit: low for len clocks, then GAP clocks high; outputs must not move
  task automatic send_bit(input int len);
    line_i = 1'b0;
    repeat (len) @(negedge clk);
    line_i = 1'b1;
    if (len >= int'(glitch_i)) begin
      sreg_m = {sreg_m[6:0], (len > int'(thresh_i)) ? 1'b0 : 1'b1};
      pend_m = 1'b1;
    end
    repeat (GAP) @(negedge clk);
    chk("R7 hold", int'(par_o), int'(out_m));
    chk("R7 nostrobe", int'(strobe_o), 0);
  endtask

  // Hold high and check the update lands exactly at edge idle+3
  task automatic close_frame(input string req);
    repeat (int'(idle_i) + 2 - GAP) @(negedge clk);
    chk({req, " R8 before"}, int'(par_o), int'(out_m));
    chk({req, " R8 nostrobe-before"}, int'(strobe_o), 0);
    @(negedge clk);
    if (pend_m) out_m = sreg_m;
    chk({req, " R8 data"}, int'(par_o), int'(out_m));
    chk({req, " R8 strobe"}, int'(strobe_o), int'(pend_m));
    pend_m = 1'b0;
    @(negedge clk);
    chk({req, " R8 strobe-end"}, int'(strobe_o), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, input int k);
    int span;
    span = int'(thresh_i) - int'(glitch_i) + 1;
    for (int i = 7; i >= 0; i--) begin
      if (v[i]) send_bit(int'(glitch_i) + ((k + i) % span));
      else      send_bit(int'(thresh_i) + 1 + ((k + i) % 4));
    end
  endtask

  initial begin
    line_i   = 1'b1;
    rst_n    = 1'b0;
    glitch_i = 8'd2;
    thresh_i = 8'd5;
    idle_i   = 8'd6;
    sreg_m   = '0;
    out_m    = '0;
    pend_m   = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 par", int'(par_o), 0);
    chk("R1 strobe", int'(strobe_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Bit order: first bit ends at the top output
    send_byte(8'hA5, 0);
    close_frame("R6");
    chk("R6 msb", int'(par_o[7]), 1);
    chk("R6 lsb", int'(par_o[0]), 1);

    // Every byte value, low lengths spanning both decision boundaries
    for (int v = 0; v < 256; v++) begin
      send_byte(8'(v), v);
      close_frame("R2 R3");
    end

    // Dips below the glitch count between real bits
    begin
      logic [7:0] pat;
      pat = 8'h3C;
      for (int i = 7; i >= 0; i--) begin
        send_bit(1);
        send_bit(pat[i] ? 2 : 7);
      end
      close_frame("R5");
      chk("R5 value", int'(par_o), 8'h3C);
    end

    // A lone glitch: nothing pending, no update
    send_bit(1);
    close_frame("R9");

    // Short frame shifts old contents; long frame keeps last eight
    send_bit(3); send_bit(9); send_bit(3);
    close_frame("R10 short");
    for (int i = 0; i < 11; i++) send_bit((i % 3 == 0) ? 8 : 4);
    close_frame("R10 long");

    // Saturation: a very long low must still decode as zero
    thresh_i = 8'd250;
    send_bit(300);
    for (int i = 0; i < 7; i++) send_bit(3);
    close_frame("R4");
    chk("R4 top", int'(par_o[7]), 0);
    thresh_i = 8'd5;

    // Longer idle timeout
    idle_i = 8'd12;
    send_byte(8'h96, 3);
    close_frame("R8 idle12");

    // Reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 mid par", int'(par_o), 0);
    chk("R1 mid strobe", int'(strobe_o), 0);
    rst_n = 1'b1;
    sreg_m = '0; out_m = '0; pend_m = 1'b0;
    repeat (4) @(negedge clk);
    send_bit(3); send_bit(3);
    close_frame("R1 post");
    chk("R1 cleared shift", int'(par_o), 8'h03);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule